// File: doc/BRIEF.md
# SDRAM Burst Data-Mask and Auto-Precharge Timer

This unit follows one SDRAM read or write burst from the cycle its command is issued. It produces the per-cycle controls a memory controller needs alongside that burst. For reads it gives a data-output enable that covers the beats the device returns, which start after the CAS latency. Byte-mask input sampled two cycles earlier pulls that enable low. For writes it flags each beat. It also flags a masked beat in the same cycle the mask input is high. When the command asked for auto-precharge, it emits a single-cycle precharge-start pulse carrying the bank number.

For a read, the precharge point is placed a CAS-latency-dependent number of clocks ahead of the final data beat. At latency 2 the lead is one clock, at latency 3 it is two, and at latency 4 it is three. For a write, the pulse comes after the final beat plus a write-recovery delay. Only one burst is tracked. A fresh command takes over from whatever was in flight, starting in its own issue cycle.

No data stream passes through this block. Commands are single-cycle events on a plain strobe, and the unit accepts them in every cycle, so there is no back-pressure. All outputs are plain per-cycle controls.

Top module: `sdram_burst_timer`

## Requirements
- R1: After reset is released and while no command has been issued, rd_oe, wr_beat, wr_mask and pre_start stay low, whatever dqm does. pre_bank reads zero.
- R2: A read issued in cycle t with cas_lat = CL (legal values 2, 3, 4) and cmd_blen code c drives rd_oe high in cycles t+CL through t+CL+BL-1, given that dqm stays low. The burst length BL for codes 0, 1, 2, 3 is 1, 2, 4, 8.
- R3: When dqm is high in cycle u, rd_oe is low in cycle u+2. A dqm pulse removes only that one read beat.
- R4: A write issued in cycle t drives wr_beat high in cycles t through t+BL-1, and low otherwise.
- R5: wr_mask is high exactly in the write-beat cycles where dqm is high in that same cycle. dqm outside a write beat leaves wr_mask low.
- R6: A read issued with cmd_autopre high gives one pre_start pulse in cycle (t+CL+BL-1)-(CL-1). That is one, two or three clocks before the last beat for CL 2, 3, 4. pre_bank equals the issued cmd_bank in that cycle.
- R7: A write issued with cmd_autopre high gives one pre_start pulse in cycle t+BL-1+WR_REC, with pre_bank equal to the issued bank.
- R8: A read or write issued with cmd_autopre low produces no pre_start pulse.
- R9: A command in cycle t ends the previous burst from cycle t onward. None of the old burst's remaining read beats or pending precharge appear.
- R10: cas_lat and cmd_blen are captured at issue. Changing them later has no effect on the tracked burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A read or write command is issued this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_autopre | input | 1 | Request precharge after the burst |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_blen | input | 2 | Burst-length code: 0,1,2,3 = 1,2,4,8 beats |
| cas_lat | input | CL_W | CAS latency in clocks (2 to MAX_CL) |
| dqm | input | 1 | Byte mask / output-disable request |
| rd_oe | output | 1 | Read data-output enable for this cycle |
| wr_beat | output | 1 | This cycle carries a write beat |
| wr_mask | output | 1 | This write beat is masked |
| pre_start | output | 1 | Internal precharge starts this cycle |
| pre_bank | output | BANK_W | Bank to precharge, valid with pre_start |

## Verification
The bench builds the block with BANK_W = 2, MAX_CL = 4 and WR_REC = 3. Because WR_REC = 3 is not the default, write-side precharge timing cannot match by accident. Every burst-length code is swept against every legal CAS latency with auto-precharge on, which covers the case where the read precharge point lands inside the beat window and the one-beat case where it lands just after issue. The replacement scenario is arranged so the overridden read's precharge would fall in the same cycle as the new write's. Only the bank number can then tell them apart.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  // Burst length in beats from the 2-bit code: 0,1,2,3 -> 1,2,4,8
  function automatic logic [3:0] blen_of(input logic [1:0] code);
    return 4'(1) << code;
  endfunction
endpackage

// File: rtl/sdt_track.sv
module sdt_track #(
  parameter int CNT_W  = 5,
  parameter int CL_W   = 3,
  parameter int BANK_W = 2,
  parameter int WR_REC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_autopre,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [1:0]        cmd_blen,
  input  logic [CL_W-1:0]   cas_lat,
  output logic              trk_active,
  output logic              trk_write,
  output logic              trk_autopre,
  output logic [BANK_W-1:0] trk_bank,
  output logic [3:0]        trk_bl,
  output logic [CL_W-1:0]   trk_cl,
  output logic [CNT_W-1:0]  trk_cnt
);
  import sdt_pkg::*;

  logic [CNT_W-1:0] end_cnt;

  // Last cycle the burst still needs: final read beat, final write beat,
  // or the write-recovery precharge point.
  always_comb begin
    if (!trk_write)
      end_cnt = CNT_W'(trk_cl) + CNT_W'(trk_bl) - CNT_W'(1);
    else if (trk_autopre)
      end_cnt = CNT_W'(trk_bl) - CNT_W'(1) + CNT_W'(WR_REC);
    else
      end_cnt = CNT_W'(trk_bl) - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_active  <= 1'b0;
      trk_write   <= 1'b0;
      trk_autopre <= 1'b0;
      trk_bank    <= '0;
      trk_bl      <= 4'd1;
      trk_cl      <= CL_W'(2);
      trk_cnt     <= '0;
    end else if (cmd_valid) begin
      trk_active  <= 1'b1;
      trk_write   <= cmd_write;
      trk_autopre <= cmd_autopre;
      trk_bank    <= cmd_bank;
      trk_bl      <= blen_of(cmd_blen);
      trk_cl      <= cas_lat;
      trk_cnt     <= CNT_W'(1);
    end else if (trk_active) begin
      if (trk_cnt >= end_cnt) trk_active <= 1'b0;
      else                    trk_cnt    <= trk_cnt + CNT_W'(1);
    end
  end

  assert_issue_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (trk_active && trk_cnt == CNT_W'(1)));
endmodule

// File: rtl/sdt_dq_ctl.sv
module sdt_dq_ctl #(
  parameter int CNT_W  = 5,
  parameter int CL_W   = 3,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dqm,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             trk_active,
  input  logic             trk_write,
  input  logic [3:0]       trk_bl,
  input  logic [CL_W-1:0]  trk_cl,
  input  logic [CNT_W-1:0] trk_cnt,
  output logic             rd_oe,
  output logic             wr_beat,
  output logic             wr_mask
);
  logic [RD_LAT-1:0] dpipe;
  logic              rd_window;
  logic              wr_window;

  // Delay line for the read-side output disable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dpipe[0] <= 1'b0;
    else        dpipe[0] <= dqm;
  end

  for (genvar i = 1; i < RD_LAT; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dpipe[i] <= 1'b0;
      else        dpipe[i] <= dpipe[i-1];
    end
  end

  always_comb begin
    rd_window = trk_active && !trk_write &&
                (trk_cnt >= CNT_W'(trk_cl)) &&
                (trk_cnt <  CNT_W'(trk_cl) + CNT_W'(trk_bl));
    wr_window = trk_active && trk_write && (trk_cnt < CNT_W'(trk_bl));
    // A command in this cycle overrides the burst being tracked
    rd_oe   = !cmd_valid && rd_window && !dpipe[RD_LAT-1];
    wr_beat = cmd_valid ? cmd_write : wr_window;
    wr_mask = wr_beat && dqm;
  end

  assert_rd_mask_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dqm, RD_LAT) |-> !rd_oe);
  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_oe && wr_beat));
endmodule

// File: rtl/sdt_precharge.sv
module sdt_precharge #(
  parameter int CNT_W  = 5,
  parameter int CL_W   = 3,
  parameter int BANK_W = 2,
  parameter int WR_REC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              trk_active,
  input  logic              trk_write,
  input  logic              trk_autopre,
  input  logic [BANK_W-1:0] trk_bank,
  input  logic [3:0]        trk_bl,
  input  logic [CL_W-1:0]   trk_cl,
  input  logic [CNT_W-1:0]  trk_cnt,
  output logic              pre_start,
  output logic [BANK_W-1:0] pre_bank
);
  logic [CNT_W-1:0] last_beat;
  logic [CNT_W-1:0] lead;
  logic [CNT_W-1:0] pre_at;

  always_comb begin
    if (trk_write) begin
      last_beat = CNT_W'(trk_bl) - CNT_W'(1);
      pre_at    = last_beat + CNT_W'(WR_REC);
      lead      = '0;
    end else begin
      last_beat = CNT_W'(trk_cl) + CNT_W'(trk_bl) - CNT_W'(1);
      lead      = CNT_W'(trk_cl) - CNT_W'(1);   // 1,2,3 clocks for CL 2,3,4
      pre_at    = last_beat - lead;
    end
    pre_start = !cmd_valid && trk_active && trk_autopre && (trk_cnt == pre_at);
    pre_bank  = pre_start ? trk_bank : '0;
  end

  assert_pre_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |=> !pre_start);
endmodule

// File: rtl/sdram_burst_timer.sv
module sdram_burst_timer #(
  parameter int BANK_W = 2,
  parameter int MAX_CL = 4,
  parameter int WR_REC = 2,
  parameter int RD_LAT = 2,
  parameter int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_autopre,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [1:0]        cmd_blen,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic              dqm,
  output logic              rd_oe,
  output logic              wr_beat,
  output logic              wr_mask,
  output logic              pre_start,
  output logic [BANK_W-1:0] pre_bank
);
  localparam int CNT_MAX = MAX_CL + 8 + WR_REC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              trk_active;
  logic              trk_write;
  logic              trk_autopre;
  logic [BANK_W-1:0] trk_bank;
  logic [3:0]        trk_bl;
  logic [CL_W-1:0]   trk_cl;
  logic [CNT_W-1:0]  trk_cnt;

  sdt_track #(.CNT_W(CNT_W), .CL_W(CL_W), .BANK_W(BANK_W), .WR_REC(WR_REC)) u_track (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_autopre(cmd_autopre),
    .cmd_bank(cmd_bank), .cmd_blen(cmd_blen), .cas_lat(cas_lat),
    .trk_active(trk_active), .trk_write(trk_write), .trk_autopre(trk_autopre),
    .trk_bank(trk_bank), .trk_bl(trk_bl), .trk_cl(trk_cl), .trk_cnt(trk_cnt)
  );

  sdt_dq_ctl #(.CNT_W(CNT_W), .CL_W(CL_W), .RD_LAT(RD_LAT)) u_dq (
    .clk(clk), .rst_n(rst_n), .dqm(dqm),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .trk_active(trk_active), .trk_write(trk_write),
    .trk_bl(trk_bl), .trk_cl(trk_cl), .trk_cnt(trk_cnt),
    .rd_oe(rd_oe), .wr_beat(wr_beat), .wr_mask(wr_mask)
  );

  sdt_precharge #(.CNT_W(CNT_W), .CL_W(CL_W), .BANK_W(BANK_W), .WR_REC(WR_REC)) u_pre (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .trk_active(trk_active), .trk_write(trk_write), .trk_autopre(trk_autopre),
    .trk_bank(trk_bank), .trk_bl(trk_bl), .trk_cl(trk_cl), .trk_cnt(trk_cnt),
    .pre_start(pre_start), .pre_bank(pre_bank)
  );
endmodule

// File: tb/sim_sdram_burst_timer.sv
module sim_sdram_burst_timer;
  localparam int CLK_P = 10;
  localparam int TWR   = 3;
  localparam int NC    = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_autopre = 1'b0;
  logic [1:0] cmd_bank = '0, cmd_blen = '0;
  logic [2:0] cas_lat = 3'd2;
  logic dqm = 1'b0;
  logic rd_oe, wr_beat, wr_mask, pre_start;
  logic [1:0] pre_bank;

  int total = 0, bad = 0;
  bit done = 0;

  bit pv[NC], pw[NC], pa[NC], pd[NC];
  logic [1:0] pb[NC], pc[NC];
  logic [2:0] pl[NC];
  logic [31:0] g_oe, g_wb, g_wm, g_pre;
  logic [1:0] g_bank;

  always #(CLK_P/2) clk = ~clk;

  sdram_burst_timer #(.BANK_W(2), .MAX_CL(4), .WR_REC(TWR)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_autopre(cmd_autopre), .cmd_bank(cmd_bank), .cmd_blen(cmd_blen),
    .cas_lat(cas_lat), .dqm(dqm), .rd_oe(rd_oe), .wr_beat(wr_beat),
    .wr_mask(wr_mask), .pre_start(pre_start), .pre_bank(pre_bank)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic clear_pat();
    for (int k = 0; k < NC; k++) begin
      pv[k] = 0; pw[k] = 0; pa[k] = 0; pd[k] = 0;
      pb[k] = 0; pc[k] = 0; pl[k] = 3'd2;
    end
  endtask

  task automatic issue(input int k, input bit w, input bit ap,
                       input logic [1:0] bank, input logic [1:0] code, input int cl);
    pv[k] = 1; pw[k] = w; pa[k] = ap; pb[k] = bank; pc[k] = code; pl[k] = 3'(cl);
  endtask

  // Drive one cycle per pattern entry at the falling edge, sample 1 time unit later
  task automatic go();
    g_oe = '0; g_wb = '0; g_wm = '0; g_pre = '0; g_bank = '0;
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      cmd_valid = pv[k]; cmd_write = pw[k]; cmd_autopre = pa[k];
      cmd_bank = pb[k]; cmd_blen = pc[k]; cas_lat = pl[k]; dqm = pd[k];
      #1;
      g_oe[k] = rd_oe; g_wb[k] = wr_beat; g_wm[k] = wr_mask; g_pre[k] = pre_start;
      if (pre_start) g_bank = pre_bank;
    end
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0; cmd_autopre = 0; dqm = 0;
  endtask

  function automatic logic [31:0] span(input int lo, input int n);
    logic [31:0] v = '0;
    for (int k = lo; k < lo + n; k++) v[k] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "outputs in reset", {28'd0, rd_oe, wr_beat, wr_mask, pre_start}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); dqm = k[0]; #1;
      chk("R1", "idle outputs", {26'd0, pre_bank, rd_oe, wr_beat, wr_mask, pre_start}, 32'd0);
    end
    @(negedge clk); dqm = 0;
    @(negedge clk);
  endtask

  task automatic t_read_sweep();
    for (int cl = 2; cl <= 4; cl++)
      for (int c = 0; c < 4; c++) begin
        int bl = 1 << c;
        clear_pat();
        issue(0, 0, 1, 2'(cl + c), 2'(c), cl);
        go();
        chk("R2", $sformatf("read oe cl%0d bl%0d", cl, bl), g_oe, span(cl, bl));
        chk("R6", $sformatf("read pre cl%0d bl%0d", cl, bl), g_pre,
            span((cl + bl - 1) - (cl - 1), 1));
        chk("R6", "read pre bank", {30'd0, g_bank}, {30'd0, 2'(cl + c)});
      end
  endtask

  task automatic t_read_dqm();
    logic [31:0] e;
    clear_pat();
    issue(0, 0, 0, 2'd0, 2'd3, 3);
    pd[0] = 1; pd[3] = 1; pd[6] = 1;
    go();
    e = span(3, 8);
    e[5] = 1'b0; e[8] = 1'b0;
    chk("R3", "read oe with dqm", g_oe, e);
    chk("R5", "no write mask during read", g_wm, 32'd0);
  endtask

  task automatic t_write_sweep();
    for (int c = 0; c < 4; c++) begin
      int bl = 1 << c;
      logic [31:0] em;
      clear_pat();
      issue(0, 1, 1, 2'(c), 2'(c), 2);
      pd[1] = 1; pd[9] = 1;
      go();
      em = '0;
      if (bl > 1) em[1] = 1'b1;
      chk("R4", $sformatf("write beats bl%0d", bl), g_wb, span(0, bl));
      chk("R5", $sformatf("write mask bl%0d", bl), g_wm, em);
      chk("R7", $sformatf("write pre bl%0d", bl), g_pre, span(bl - 1 + TWR, 1));
      chk("R7", "write pre bank", {30'd0, g_bank}, {30'd0, 2'(c)});
      chk("R2", "no read oe during write", g_oe, 32'd0);
    end
  endtask

  task automatic t_no_ap();
    clear_pat();
    issue(0, 0, 0, 2'd1, 2'd2, 3);
    go();
    chk("R8", "read without autopre", g_pre, 32'd0);
    chk("R2", "read oe cl3 bl4", g_oe, span(3, 4));
    clear_pat();
    issue(0, 1, 0, 2'd1, 2'd3, 2);
    go();
    chk("R8", "write without autopre", g_pre, 32'd0);
  endtask

  task automatic t_replace();
    clear_pat();
    issue(0, 0, 1, 2'd1, 2'd3, 4);
    issue(4, 1, 1, 2'd3, 2'd1, 2);
    go();
    chk("R9", "old read beats dropped", g_oe, 32'd0);
    chk("R9", "new write beats", g_wb, span(4, 2));
    chk("R9", "only new precharge", g_pre, span(4 + 1 + TWR, 1));
    chk("R9", "precharge bank of new burst", {30'd0, g_bank}, 32'd3);
  endtask

  task automatic t_capture();
    clear_pat();
    issue(0, 0, 1, 2'd2, 2'd2, 2);
    for (int k = 1; k < NC; k++) begin pl[k] = 3'd4; pc[k] = 2'd0; end
    go();
    chk("R10", "read oe keeps issue cl/bl", g_oe, span(2, 4));
    chk("R10", "pre keeps issue bl", g_pre, span(4, 1));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read_sweep();
    t_read_dqm();
    t_write_sweep();
    t_no_ap();
    t_replace();
    t_capture();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule